// File: doc/BRIEF.md
# DRAM Profiling Counter Unit

This block sits next to a DRAM controller and measures its traffic. Six counters track elapsed clock cycles, cycles in which the controller reports itself busy, accepted read and write transactions, and the bytes moved by those reads and writes. The controller drives simple per-cycle strobes. A read or write strobe carries a byte count of up to `MAX_LEN` bytes. A busy level needs no count.

Software reaches the unit through a small memory-mapped register window. The control word holds an enable bit, a self-clearing counter-reset bit, a freeze bit and a sticky overflow flag for the cycle counter. The six counters are read-only and wrap modulo 2^`CNT_W`. Software widens them by taking differences between successive reads. A profiling run starts with a write of the reset bit, followed by a write of the enable bit.

Top module: `mprof_unit`

## Requirements
- R1: The control word is at offset 0x410. Bit 0 is enable and bit 2 is freeze; both read back as last written. Bit 1 (counter reset) always reads 0. Bits 31:4 read 0.
- R2: Counters are read at 0x418, 0x41C, 0x420, 0x424, 0x428 and 0x42C. These hold, in turn: total cycles, busy cycles, read accesses, write accesses, read bytes and write bytes. Writes to these offsets leave every counter unchanged. A read of any other offset, including a misaligned one, returns 0.
- R3: While counting is active, the total-cycle counter rises by exactly one per clock.
- R4: While counting is active, the busy-cycle counter rises by one only on clocks where `mc_busy` is 1.
- R5: While counting is active, the read-access and write-access counters each add one per clock on which their strobe is 1.
- R6: While counting is active, the read-byte and write-byte counters add the accompanying length (0 to 64) on each clock on which their strobe is 1.
- R7: Counting is active only while enable is 1 and freeze is 0, so freeze overrides enable. While counting is inactive, all six counters hold their values and stay readable.
- R8: A control write with bit 1 set clears all six counters and the overflow flag at that same clock edge, and no event is counted on that edge. A control write changes enable and freeze at its own edge, so counting follows from the next clock.
- R9: When the total-cycle counter wraps from all ones to zero, the overflow flag (bit 3 of the control word) becomes 1 and stays set. Writing 1 to bit 3 clears it, unless a wrap happens on the same edge, in which case the flag stays 1.
- R10: Every counter wraps modulo 2^`CNT_W`.
- R11: After reset, the control word and all counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset, used for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| mc_busy | input | 1 | Controller busy this cycle |
| rd_go | input | 1 | Read transaction accepted this cycle |
| rd_len | input | LEN_W | Bytes in the accepted read |
| wr_go | input | 1 | Write transaction accepted this cycle |
| wr_len | input | LEN_W | Bytes in the accepted write |

## Verification
On every cycle, the bound checker checks the clock-to-clock relations of the counters. These are: the unit step of the total counter, the hold while inactive or when busy is low, the access increments, the clear on a reset write, and the setting and stickiness of the overflow flag. Some behaviour can only be shown by the bench's scenarios, which compare values read through the register window. This includes the address map and the zero returned for unmapped reads, and the ignored writes to counter offsets. It also includes the byte sums built up over random traffic, and the one-cycle delay between a control write and its effect. The wrap and the overflow flag are exercised on a second instance with 8-bit counters, including a flag clear that lands on the wrap edge.

// File: rtl/mprof_pkg.sv
package mprof_pkg;
  localparam int NUM_EVT = 6;
  localparam int ADDR_W  = 12;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h410;
  localparam logic [ADDR_W-1:0] CNT_BASE = 12'h418;

  // event order fixes the counter offsets
  localparam int EV_TOTAL  = 0;
  localparam int EV_BUSY   = 1;
  localparam int EV_RDACC  = 2;
  localparam int EV_WRACC  = 3;
  localparam int EV_RDBYTE = 4;
  localparam int EV_WRBYTE = 5;

  // control word bit positions
  localparam int B_EN  = 0;
  localparam int B_CLR = 1;
  localparam int B_FRZ = 2;
  localparam int B_OVF = 3;

  function automatic logic [ADDR_W-1:0] cnt_ofs(input int idx);
    return CNT_BASE + ADDR_W'(idx * 4);
  endfunction
endpackage

// File: rtl/mprof_ctl.sv
module mprof_ctl
  import mprof_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [3:0] wbits,
  input  logic       tot_wrap,
  output logic       en_o,
  output logic       frz_o,
  output logic       ovf_o,
  output logic       clr_o,
  output logic       wipe_o,
  output logic       active_o
);
  logic en_q, frz_q, ovf_q;

  assign clr_o    = wr_ctrl & wbits[B_CLR];
  assign wipe_o   = wr_ctrl & wbits[B_OVF];
  assign active_o = en_q & ~frz_q;
  assign en_o     = en_q;
  assign frz_o    = frz_q;
  assign ovf_o    = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      frz_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wbits[B_EN];
        frz_q <= wbits[B_FRZ];
      end
      if (clr_o)         ovf_q <= 1'b0;
      else if (tot_wrap) ovf_q <= 1'b1;   // a wrap beats a clear request
      else if (wipe_o)   ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mprof_ctr.sv
module mprof_ctr #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] cur,
                                            input logic [STEP_W-1:0] stp);
    return cur + CNT_W'(stp);   // modulo 2^CNT_W
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= bump(cnt_q, step);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mprof_rdmux.sv
module mprof_rdmux
  import mprof_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [3:0]               ctrl_word,
  input  logic [NUM_EVT*CNT_W-1:0] cnt_flat,
  output logic [31:0]              rdata
);
  always_comb begin
    rdata = '0;
    if (addr == CTRL_OFS) rdata = {28'b0, ctrl_word};
    for (int i = 0; i < NUM_EVT; i++) begin
      if (addr == cnt_ofs(i)) rdata = 32'(cnt_flat[i*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/mprof_unit.sv
module mprof_unit
  import mprof_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int MAX_LEN = 64,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              mc_busy,
  input  logic              rd_go,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic              wr_go,
  input  logic [LEN_W-1:0]  wr_len
);
  localparam int FLAT_W = NUM_EVT * CNT_W;

  // named internal events, observed by the bound checker
  logic              cnt_active;
  logic              ctr_clear;
  logic              ovf_wipe;
  logic              ovf_q;
  logic              tot_wrap;
  logic              en_q, frz_q;
  logic [FLAT_W-1:0] cnt_flat;
  logic [LEN_W-1:0]  step_v [NUM_EVT];
  logic              wr_ctrl;
  logic              wdata_unused;

  assign wr_ctrl      = bus_wr & (bus_addr == CTRL_OFS);
  assign wdata_unused = ^bus_wdata[31:4];
  assign tot_wrap     = cnt_active & ~ctr_clear & (&cnt_flat[EV_TOTAL*CNT_W +: CNT_W]);

  always_comb begin
    step_v[EV_TOTAL]  = LEN_W'(1);
    step_v[EV_BUSY]   = LEN_W'(mc_busy);
    step_v[EV_RDACC]  = LEN_W'(rd_go);
    step_v[EV_WRACC]  = LEN_W'(wr_go);
    step_v[EV_RDBYTE] = rd_go ? rd_len : '0;
    step_v[EV_WRBYTE] = wr_go ? wr_len : '0;
  end

  mprof_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wbits    (bus_wdata[3:0]),
    .tot_wrap (tot_wrap),
    .en_o     (en_q),
    .frz_o    (frz_q),
    .ovf_o    (ovf_q),
    .clr_o    (ctr_clear),
    .wipe_o   (ovf_wipe),
    .active_o (cnt_active)
  );

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_ctr
    mprof_ctr #(.CNT_W(CNT_W), .STEP_W(LEN_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctr_clear),
      .adv   (cnt_active),
      .step  (step_v[e]),
      .cnt_o (cnt_flat[e*CNT_W +: CNT_W])
    );
  end

  mprof_rdmux #(.CNT_W(CNT_W)) u_rd (
    .addr      (bus_addr),
    .ctrl_word ({ovf_q, 1'b0, frz_q, en_q}),
    .cnt_flat  (cnt_flat),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/mprof_chk.sv
module mprof_chk
  import mprof_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       active,
  input logic                       clr,
  input logic                       wipe,
  input logic                       ovf,
  input logic                       busy,
  input logic                       rd_go,
  input logic                       wr_go,
  input logic [NUM_EVT*CNT_W-1:0]   cnt_flat
);
  logic [CNT_W-1:0] tot, bsy, rda, wra;
  assign tot = cnt_flat[EV_TOTAL*CNT_W +: CNT_W];
  assign bsy = cnt_flat[EV_BUSY*CNT_W  +: CNT_W];
  assign rda = cnt_flat[EV_RDACC*CNT_W +: CNT_W];
  assign wra = cnt_flat[EV_WRACC*CNT_W +: CNT_W];

  assert_total_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr) |=> tot == $past(tot) + CNT_W'(1));

  assert_busy_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr && !busy) |=> $stable(bsy));

  assert_rd_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr) |=> rda == $past(rda) + CNT_W'($past(rd_go)));

  assert_wr_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr) |=> wra == $past(wra) + CNT_W'($past(wr_go)));

  assert_hold_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clr) |=> $stable(cnt_flat));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_flat == '0) && !ovf);

  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr && (&tot)) |=> ovf);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr && !wipe) |=> ovf);
endmodule

bind mprof_unit mprof_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .active   (cnt_active),
  .clr      (ctr_clear),
  .wipe     (ovf_wipe),
  .ovf      (ovf_q),
  .busy     (mc_busy),
  .rd_go    (rd_go),
  .wr_go    (wr_go),
  .cnt_flat (cnt_flat)
);

// File: tb/mprof_unit_tb.sv
`timescale 1ns/1ps
module mprof_unit_tb_top;
  localparam int NEV = 6;
  localparam logic [11:0] A_CTRL = 12'h410;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_w, rdata_s;
  logic        mc_busy = 1'b0, rd_go = 1'b0, wr_go = 1'b0;
  logic [6:0]  rd_len = '0, wr_len = '0;

  always #4 clk = ~clk;   // 125 MHz

  mprof_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_w), .mc_busy(mc_busy),
    .rd_go(rd_go), .rd_len(rd_len), .wr_go(wr_go), .wr_len(wr_len));

  mprof_unit #(.CNT_W(8)) dut_s (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .mc_busy(mc_busy),
    .rd_go(rd_go), .rd_len(rd_len), .wr_go(wr_go), .wr_len(wr_len));

  // reference state
  longint unsigned m_cnt [NEV];
  bit m_en, m_frz, m_ovf_w, m_ovf_s;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [11:0] ofs(input int i);
    return 12'h418 + 12'(4 * i);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a, input int w, input bit ovf);
    longint unsigned mask = (w == 32) ? 64'hFFFF_FFFF : ((64'd1 << w) - 1);
    logic [31:0] r = '0;
    if (a == A_CTRL) r = {28'b0, ovf, 1'b0, m_frz, m_en};
    for (int i = 0; i < NEV; i++) if (a == ofs(i)) r = 32'(m_cnt[i] & mask);
    return r;
  endfunction

  task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, optionally compare reads, advance the model
  task automatic cycle(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                       input bit bz, input bit rg, input logic [6:0] rl,
                       input bit wg, input logic [6:0] wl, input bit chk, input string tag);
    bit act, clr, wipe, wctl;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    mc_busy = bz; rd_go = rg; rd_len = rl; wr_go = wg; wr_len = wl;
    #1;
    if (chk) begin
      compare({tag, " w32"}, rdata_w, exp_rd(a, 32, m_ovf_w));
      compare({tag, " w8"},  rdata_s, exp_rd(a, 8,  m_ovf_s));
    end
    act  = m_en && !m_frz;
    wctl = wr && (a == A_CTRL);
    clr  = wctl && wd[1];
    wipe = wctl && wd[3];
    if (clr) begin
      for (int i = 0; i < NEV; i++) m_cnt[i] = 0;
      m_ovf_w = 0; m_ovf_s = 0;
    end else begin
      if (act && (m_cnt[0] & 64'hFF) == 64'hFF) m_ovf_s = 1;
      else if (wipe) m_ovf_s = 0;
      if (act && (m_cnt[0] & 64'hFFFF_FFFF) == 64'hFFFF_FFFF) m_ovf_w = 1;
      else if (wipe) m_ovf_w = 0;
      if (act) begin
        m_cnt[0] += 1;
        m_cnt[1] += bz;
        m_cnt[2] += rg;
        m_cnt[3] += wg;
        m_cnt[4] += rg ? rl : 0;
        m_cnt[5] += wg ? wl : 0;
      end
    end
    if (wctl) begin m_en = wd[0]; m_frz = wd[2]; end
    @(posedge clk);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    cycle(1, a, d, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic rd_reg(input logic [11:0] a, input string tag);
    cycle(0, a, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic rd_all(input string tag);
    rd_reg(A_CTRL, tag);
    for (int i = 0; i < NEV; i++) rd_reg(ofs(i), tag);
  endtask

  task automatic traffic(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int sel = $urandom % 7;
      cycle(0, (sel == 6) ? A_CTRL : ofs(sel), 0,
            bit'($urandom % 2), bit'($urandom % 3 == 0), 7'($urandom % 65),
            bit'($urandom % 3 == 0), 7'($urandom % 65), (k % 5 == 0), tag);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NEV; i++) m_cnt[i] = 0;
    m_en = 0; m_frz = 0; m_ovf_w = 0; m_ovf_s = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd_all("R11 reset state");

    // start sequence: reset alone, then enable alone
    wr_reg(A_CTRL, 32'h2);
    wr_reg(A_CTRL, 32'h1);
    rd_reg(A_CTRL, "R1 enable readback");
    cycle(0, ofs(0), 0, 0, 0, 0, 0, 0, 1, "R8 count begins after enable");

    // directed byte lengths at the limits
    cycle(0, ofs(4), 0, 1, 1, 7'd64, 1, 7'd0, 0, "");
    cycle(0, ofs(4), 0, 0, 1, 7'd0, 1, 7'd64, 1, "R6 max and zero lengths");
    rd_reg(ofs(5), "R6 write bytes");
    rd_reg(ofs(1), "R4 busy count");

    // random traffic, wraps the 8-bit instance several times
    traffic(700, "R3 R4 R5 R6 R10 random");
    rd_all("R10 wrap after traffic");
    rd_reg(A_CTRL, "R9 overflow after wrap");

    // freeze overrides enable
    wr_reg(A_CTRL, 32'h5);
    traffic(30, "R7 frozen");
    rd_all("R7 frozen hold");
    rd_reg(A_CTRL, "R1 freeze readback");
    wr_reg(A_CTRL, 32'h4);
    traffic(10, "R7 frozen disabled");
    wr_reg(A_CTRL, 32'h0);
    traffic(10, "R7 disabled");
    rd_all("R7 disabled hold");

    // counter offsets are read-only, unmapped reads are zero
    wr_reg(ofs(0), 32'h1234_5678);
    wr_reg(ofs(4), 32'hFFFF_FFFF);
    rd_all("R2 ignored counter write");
    rd_reg(12'h414, "R2 unmapped gap");
    rd_reg(12'h41A, "R2 misaligned");
    rd_reg(12'h430, "R2 past end");
    rd_reg(12'h000, "R2 low offset");

    // reset bit reads as zero and clears everything
    wr_reg(A_CTRL, 32'h7);
    rd_reg(A_CTRL, "R1 reset bit reads 0");
    rd_all("R8 cleared by reset write");

    // overflow: set, clear, and clear on the wrap edge
    wr_reg(A_CTRL, 32'h1);
    traffic(300, "R9 run to wrap");
    rd_reg(A_CTRL, "R9 flag set");
    wr_reg(A_CTRL, 32'h9);
    rd_reg(A_CTRL, "R9 flag cleared");
    while ((m_cnt[0] & 64'hFF) != 64'hFF) cycle(0, A_CTRL, 0, 0, 0, 0, 0, 0, 0, "");
    wr_reg(A_CTRL, 32'h9);
    rd_reg(A_CTRL, "R9 wrap beats clear");

    // reset write while counting: no event counted on that edge
    cycle(1, A_CTRL, 32'h3, 1, 1, 7'd40, 1, 7'd40, 0, "");
    rd_all("R8 reset while counting");
    traffic(50, "R3 R5 after restart");
    rd_all("R3 final");

    summary();
  end
endmodule